// File: doc/BRIEF.md
# Programmable Serial Shift-Clock Generator

This block derives the shift clock of a clock-synchronous serial channel from a single base clock. It never creates a new clock net: its output is a registered level sampled in the base-clock domain. It also emits one-cycle strobes that a shift register can use as clock enables. Three sources can be selected. The first is a waveform source built on a 16-bit period counter, which gives a full output period of 2×(n+2) base clocks and a first edge delayed by a programmable phase compare value. The second is a fixed divide-by-8 prescale. The third is a power-of-two prescale chosen by a 4-bit code.

Software programs the source select, the period, the phase compare value, the prescale code, the idle level and the inversion control, and then raises the run enable. Any setting that would break the programming rules flags a configuration error and holds the clock at its idle level. Dropping the run enable restarts the timing from zero. The programming rules are: a period outside 1..65533, a phase value not below the period, a prescale ratio under 6, or the reserved select code.

Top module: `xfer_clk_gen`

## Requirements
- R1: With the waveform source (select code 0), period value n and phase value p, the first change of `sclk_o` is seen p+1 base clocks after the first rising edge that samples `run_en` high, and later changes follow every n+2 base clocks, so the full period is 2×(n+2).
- R2: With select code 0, a period value of 0 or above 0xFFFD sets `cfg_err_o` one clock later and holds `sclk_o` at `idle_lvl` with no strobes. The values 1 and 0xFFFD are accepted, and n=1 gives divide-by-6.
- R3: With select code 0, a phase value equal to or greater than the period value is a configuration error, with the same effect as in R2.
- R4: Select code 1 toggles `sclk_o` every 4 base clocks (divide-by-8). The first change comes 4 clocks after run starts.
- R5: Select code 2 with prescale code k divides by 2^k. `sclk_o` toggles every 2^(k-1) clocks, and the first change comes at 2^(k-1). Codes whose ratio is below 6 (k = 0, 1, 2) are configuration errors.
- R6: While the run enable is low or the configuration is invalid, `sclk_o` equals `idle_lvl` one base clock later, and both strobes are low.
- R7: While running, `sclk_o` starts at `idle_lvl` XOR `inv_en`. Each generated edge flips it from that level.
- R8: `lead_stb_o` is high for exactly the one cycle in which `sclk_o` leaves its starting running level. `trail_stb_o` is high for the one cycle in which it returns. The two are never high together.
- R9: Lowering `run_en` for one clock clears the counter, so a restart reproduces the first-edge timing of R1.
- R10: Select code 3 is reserved and is always a configuration error.
- R11: A synchronous active-high reset drives `sclk_o`, both strobes and `cfg_err_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source: 0 waveform, 1 divide-by-8, 2 power-of-two, 3 reserved |
| period_n | input | 16 | Waveform period value n |
| phase_c | input | 16 | Waveform phase compare value |
| pre_code | input | 4 | Power-of-two prescale code k |
| idle_lvl | input | 1 | Level held while stopped |
| inv_en | input | 1 | Inverts the running waveform |
| run_en | input | 1 | Run enable |
| sclk_o | output | 1 | Shift clock level (registered) |
| lead_stb_o | output | 1 | One-cycle strobe on the leading edge |
| trail_stb_o | output | 1 | One-cycle strobe on the trailing edge |
| cfg_err_o | output | 1 | Current settings are illegal |

## Verification
The waveform source is run with three period and phase pairs: the minimum period with zero phase, a mid period with a small phase, and a phase just below the period. These tell apart an off-by-one in the reload point from one in the compare point. The prescale sources are run with codes 3 and 5 and with the fixed divide-by-8, which separates the two half-period formulas. One waveform case raises both idle and inversion, which shows that the starting level and the strobe polarity follow the running phase and not the pin level. Illegal settings on each side of every range limit, plus a mid-period restart and the longest legal prescale, check the error flag, the hold at idle and the counter clear.

// File: rtl/xclk_pkg.sv
package xclk_pkg;
  typedef enum logic [1:0] {
    SRC_WAVE = 2'd0,
    SRC_DIV8 = 2'd1,
    SRC_POW2 = 2'd2,
    SRC_NONE = 2'd3
  } src_e;
endpackage

// File: rtl/xclk_cfg.sv
module xclk_cfg
  import xclk_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int N_MAX   = 16'hFFFD,
  parameter int MIN_DIV = 6,
  parameter int FIX_DIV = 8
) (
  input  logic [1:0]       src_sel,
  input  logic [CNT_W-1:0] period_n,
  input  logic [CNT_W-1:0] phase_c,
  input  logic [PRE_W-1:0] pre_code,
  output logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cmp,
  output logic             valid
);
  localparam int FIX_HALF = FIX_DIV / 2;

  logic [31:0] pow_div;
  logic [31:0] pow_half;

  assign pow_div  = 32'd1 << pre_code;
  assign pow_half = pow_div >> 1;

  always_comb begin
    limit = '0;
    cmp   = '0;
    valid = 1'b0;
    case (src_e'(src_sel))
      SRC_WAVE: begin
        valid = (period_n != '0) && (32'(period_n) <= N_MAX) && (phase_c < period_n);
        limit = period_n + CNT_W'(1);
        cmp   = phase_c;
      end
      SRC_DIV8: begin
        valid = 1'b1;
        limit = CNT_W'(FIX_HALF - 1);
        cmp   = CNT_W'(FIX_HALF - 1);
      end
      SRC_POW2: begin
        valid = (pow_div >= 32'(MIN_DIV));
        limit = CNT_W'(pow_half - 32'd1);
        cmp   = CNT_W'(pow_half - 32'd1);
      end
      default: begin
        valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/xclk_count.sv
module xclk_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_ok,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] cmp,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_ok) begin
      cnt <= '0;
    end else if (cnt >= limit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign tick = run_ok && (cnt == cmp);

  // R9: a stopped cycle leaves the counter at zero
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !run_ok |=> (cnt == '0));
endmodule

// File: rtl/xclk_shape.sv
module xclk_shape (
  input  logic clk,
  input  logic rst,
  input  logic run_ok,
  input  logic tick,
  input  logic idle_lvl,
  input  logic inv_en,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  logic ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= 1'b0;
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!run_ok) begin
      ph      <= 1'b0;
      sclk_o  <= idle_lvl;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= tick && !ph;
      trail_o <= tick && ph;
      if (tick) ph <= ~ph;
      sclk_o  <= idle_lvl ^ inv_en ^ (ph ^ tick);
    end
  end

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(lead_o && trail_o));

  p_lead_single_r8: assert property (@(posedge clk) disable iff (rst)
    lead_o |=> !lead_o);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !run_ok |=> (sclk_o == $past(idle_lvl)) && !lead_o && !trail_o);
endmodule

// File: rtl/xfer_clk_gen.sv
module xfer_clk_gen #(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int N_MAX   = 16'hFFFD,
  parameter int MIN_DIV = 6,
  parameter int FIX_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel,
  input  logic [CNT_W-1:0] period_n,
  input  logic [CNT_W-1:0] phase_c,
  input  logic [PRE_W-1:0] pre_code,
  input  logic             idle_lvl,
  input  logic             inv_en,
  input  logic             run_en,
  output logic             sclk_o,
  output logic             lead_stb_o,
  output logic             trail_stb_o,
  output logic             cfg_err_o
);
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cmp;
  logic             valid;
  logic             run_ok;
  logic             tick;

  xclk_cfg #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .N_MAX(N_MAX),
    .MIN_DIV(MIN_DIV), .FIX_DIV(FIX_DIV)
  ) u_cfg (
    .src_sel(src_sel), .period_n(period_n), .phase_c(phase_c),
    .pre_code(pre_code), .limit(limit), .cmp(cmp), .valid(valid)
  );

  assign run_ok = run_en && valid;

  xclk_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run_ok(run_ok),
    .limit(limit), .cmp(cmp), .tick(tick)
  );

  xclk_shape u_shape (
    .clk(clk), .rst(rst), .run_ok(run_ok), .tick(tick),
    .idle_lvl(idle_lvl), .inv_en(inv_en),
    .sclk_o(sclk_o), .lead_o(lead_stb_o), .trail_o(trail_stb_o)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err_o <= 1'b0;
    else     cfg_err_o <= !valid;
  end

  p_sel_err_r10: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd3) |=> cfg_err_o);

  p_err_hold_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> (sclk_o == $past(idle_lvl)) && !lead_stb_o && !trail_stb_o);
endmodule

// File: tb/xfer_clk_gen_bench.sv
module xfer_clk_gen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic [1:0]  src_sel;
  logic [15:0] period_n, phase_c;
  logic [3:0]  pre_code;
  logic        idle_lvl, inv_en, run_en;
  logic        sclk, lead, trail, err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  xfer_clk_gen u_xfer_clk_gen (
    .clk(clk), .rst(rst), .src_sel(src_sel), .period_n(period_n),
    .phase_c(phase_c), .pre_code(pre_code), .idle_lvl(idle_lvl),
    .inv_en(inv_en), .run_en(run_en), .sclk_o(sclk),
    .lead_stb_o(lead), .trail_stb_o(trail), .cfg_err_o(err)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] n;
    logic [15:0] ph;
    logic [3:0]  k;
    logic        idl;
    logic        inv;
    logic        err;
    int          first;
    int          half;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd1,      16'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1,  3},  // R1 R2 divide-by-6
    '{2'd0, 16'd5,      16'd2, 4'd0, 1'b0, 1'b0, 1'b0, 3,  7},  // R1
    '{2'd0, 16'd10,     16'd9, 4'd0, 1'b0, 1'b0, 1'b0, 10, 12}, // R1 R3 phase just below
    '{2'd1, 16'd0,      16'd0, 4'd0, 1'b1, 1'b0, 1'b0, 4,  4},  // R4
    '{2'd2, 16'd0,      16'd0, 4'd3, 1'b0, 1'b0, 1'b0, 4,  4},  // R5
    '{2'd2, 16'd0,      16'd0, 4'd5, 1'b0, 1'b0, 1'b0, 16, 16}, // R5
    '{2'd2, 16'd0,      16'd0, 4'd2, 1'b0, 1'b0, 1'b1, 0,  0},  // R5 ratio 4
    '{2'd2, 16'd0,      16'd0, 4'd0, 1'b1, 1'b0, 1'b1, 0,  0},  // R5 no division
    '{2'd0, 16'd0,      16'd0, 4'd0, 1'b0, 1'b0, 1'b1, 0,  0},  // R2 n=0
    '{2'd0, 16'hFFFE,   16'd0, 4'd0, 1'b1, 1'b0, 1'b1, 0,  0},  // R2 n too big
    '{2'd0, 16'd5,      16'd5, 4'd0, 1'b0, 1'b0, 1'b1, 0,  0},  // R3 phase == n
    '{2'd3, 16'd5,      16'd1, 4'd4, 1'b1, 1'b0, 1'b1, 0,  0},  // R10
    '{2'd0, 16'd4,      16'd1, 4'd0, 1'b1, 1'b1, 1'b0, 2,  6}   // R7 R8
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run and time three edges; stop and check the idle return (R6)
  task automatic run_measure(input int first, input int half, input logic idl,
                             input logic inv, input string req);
    int t [3];
    int got = 0;
    logic prev;
    int lim = first + 2 * half + 8;
    t = '{0, 0, 0};
    prev = idl ^ inv;
    run_en = 1'b1;
    for (int i = 1; i <= lim && got < 3; i++) begin
      @(negedge clk);
      if (i == 1 && first > 1) chk(sclk == (idl ^ inv), {req, " R7 start level"}, sclk, idl ^ inv);
      if (sclk !== prev) begin
        t[got] = i;
        if (got == 0) chk(lead === 1'b1 && trail === 1'b0, {req, " R8 lead strobe"}, lead, 1);
        if (got == 1) chk(trail === 1'b1 && lead === 1'b0, {req, " R8 trail strobe"}, trail, 1);
        got++;
        prev = sclk;
      end else begin
        chk(!lead && !trail, {req, " R8 no stray strobe"}, lead | trail, 0);
      end
    end
    chk(got == 3, {req, " edge count"}, got, 3);
    chk(t[0] == first, {req, " first edge"}, t[0], first);
    chk(t[1] - t[0] == half, {req, " half period 1"}, t[1] - t[0], half);
    chk(t[2] - t[1] == half, {req, " half period 2"}, t[2] - t[1], half);
    run_en = 1'b0;
    @(negedge clk);
    chk(sclk == idl && !lead && !trail, {req, " R6 idle after stop"}, sclk, idl);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; src_sel = 2'd3; period_n = '0; phase_c = '0; pre_code = '0;
    idle_lvl = 1'b1; inv_en = 1'b1; run_en = 1'b1;
    @(negedge clk); @(negedge clk);
    // R11: reset values
    chk(sclk == 0 && lead == 0 && trail == 0 && err == 0, "R11 reset state",
        {sclk, lead, trail, err}, 0);
    run_en = 1'b0; inv_en = 1'b0;
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      src_sel = VECS[v].sel; period_n = VECS[v].n; phase_c = VECS[v].ph;
      pre_code = VECS[v].k; idle_lvl = VECS[v].idl; inv_en = VECS[v].inv;
      run_en = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(err == VECS[v].err, $sformatf("vec%0d R2 R3 R5 R10 error flag", v), err, VECS[v].err);
      chk(sclk == VECS[v].idl, $sformatf("vec%0d R6 idle before run", v), sclk, VECS[v].idl);
      if (!VECS[v].err) begin
        run_measure(VECS[v].first, VECS[v].half, VECS[v].idl, VECS[v].inv,
                    $sformatf("vec%0d", v));
      end else begin
        int bad = 0;
        run_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          if (sclk != VECS[v].idl || lead || trail) bad++;
        end
        chk(bad == 0, $sformatf("vec%0d R2 held at idle", v), bad, 0);
        run_en = 1'b0;
        @(negedge clk);
      end
    end

    // R9: restart mid-period reproduces first-edge timing
    src_sel = 2'd0; period_n = 16'd5; phase_c = 16'd2; pre_code = '0;
    idle_lvl = 1'b0; inv_en = 1'b0; run_en = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R9 stop level", sclk, 0);
    run_measure(3, 7, 1'b0, 1'b0, "R9 restart");

    // R2: largest legal period is accepted, first edge at once
    src_sel = 2'd0; period_n = 16'hFFFD; phase_c = 16'd0; run_en = 1'b0;
    @(negedge clk);
    chk(err == 1'b0, "R2 n=0xFFFD legal", err, 0);
    run_en = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1 && lead == 1'b1, "R1 R2 first edge at n=0xFFFD", sclk, 1);
    @(negedge clk);
    chk(sclk == 1'b1 && !lead, "R8 single-cycle lead", lead, 0);
    run_en = 1'b0;
    @(negedge clk);

    // R5: longest prescale code
    src_sel = 2'd2; pre_code = 4'd15;
    @(negedge clk);
    chk(err == 1'b0, "R5 k=15 legal", err, 0);
    run_measure(16384, 16384, 1'b0, 1'b0, "R5 k=15");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule